// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is the management-channel master of an Ethernet media access controller. Software loads a 32-bit frame register with the fields of one management transaction and a divider register with the management clock rate. The block then shifts that word out to an attached PHY on the MDC/MDIO pair: a run of ones as preamble, then the 32 register bits most significant first. When the operation field encodes a read, the block releases MDIO during the turnaround and data phases. It stores the 16 bits the PHY returns in the low half of the frame register, where software can read them back.

The two registers can be programmed in either order. A frame written while the divider is zero is kept and marked pending. No frame goes out until the divider is given a nonzero value, and that divider write launches the stored frame. A one-cycle completion pulse marks the end of every frame.

Top module: `mdio_frame_master`

## Requirements
- R1: Writing the frame register (`reg_sel` = 0) while idle and with a nonzero divider starts a frame on the next clock. MDIO carries 32 ones and then frame bits 31 down to 0. MDIO is captured on MDC rising edges.
- R2: MDC is low whenever no frame is running. During a frame, each MDC high phase and each MDC low phase lasts exactly `divider` system clocks.
- R3: Writing the frame register while the divider is zero starts no frame and produces no MDC activity. The written word reads back unchanged from `reg_rdata` with `reg_sel` = 0.
- R4: While a frame is pending, a divider write (`reg_sel` = 1) with a nonzero value launches the most recently written frame word. A divider write of zero leaves the frame pending and the lines idle.
- R5: MDIO output changes only together with a falling MDC edge while the line is driven.
- R6: `frame_done` is high for exactly one clock, in the cycle in which the final MDC falling edge occurs.
- R7: When frame bits [29:28] equal 2'b10 (read), `mdio_oe` is low from the second turnaround bit (frame bit 16) through frame bit 0. The bits sampled in that data phase replace frame register bits [15:0]. Bits [31:16] keep the written value.
- R8: Frame register writes made while a frame is running are ignored. They do not alter the register and they start no further frame.
- R9: The divider is taken from `reg_wdata[DIV_W-1:0]` and reads back zero-extended. It resets to 0. A divider write during a frame leaves that frame's MDC rate unchanged.
- R10: After reset, `mdc`, `mdio_oe` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 frame word, 1 divider |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdio_i | input | 1 | MDIO level returned from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Write frames and read frames are sent with distinct field values and divider settings of 1 to 4. Comparing every bit captured on MDC rising edges tells bit order and preamble length apart. The enable pattern and the read-back of the returned data separate the write opcode from the read opcode. Frames are also written in three other situations: during a running frame, with the divider at zero followed by an overwrite and a zero divider write, and with a divider change in mid-frame. These cases separate ignoring, holding and relaunching, and they show that the rate is latched per frame rather than followed live.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_W = 32;
   localparam int DATA_W  = 16;
   localparam int POS_W   = $clog2(FRAME_W);
   localparam logic [1:0] OP_READ = 2'b10;

   typedef enum logic {
      SEL_FRAME = 1'b0,
      SEL_DIV   = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 sel,
   input  logic [FRAME_W-1:0]   wdata,
   output logic [FRAME_W-1:0]   rdata,
   input  logic                 busy,
   input  logic                 cap_en,
   input  logic [POS_W-1:0]     cap_pos,
   input  logic                 cap_bit,
   output logic [FRAME_W-1:0]   frame,
   output logic [DIV_W-1:0]     div,
   output logic                 pending,
   output logic                 start,
   output logic [DIV_W-1:0]     launch_div
);
   logic [FRAME_W-1:0] frame_q;
   logic [DIV_W-1:0]   div_q;
   logic [DIV_W-1:0]   div_new;
   logic [FRAME_W-1:0] div_ext;
   logic               pend_q;
   logic               frame_wr;
   logic               div_wr;
   logic               div_launch;

   assign frame_wr   = wr_en && (sel == SEL_FRAME) && !busy;
   assign div_wr     = wr_en && (sel == SEL_DIV);
   assign div_new    = wdata[DIV_W-1:0];
   assign div_launch = div_wr && pend_q && !busy && (div_new != '0);

   assign start      = (frame_wr && (div_q != '0)) || div_launch;
   assign launch_div = frame_wr ? div_q : div_new;

   // frame word has no defined reset value
   always_ff @(posedge clk) begin
      if (frame_wr)
         frame_q <= wdata;
      else if (cap_en)
         frame_q[cap_pos] <= cap_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (div_wr)
            div_q <= div_new;
         if (frame_wr)
            pend_q <= (div_q == '0);
         else if (div_launch)
            pend_q <= 1'b0;
      end
   end

   generate
      if (DIV_W < FRAME_W) begin : g_div_pad
         assign div_ext = {{(FRAME_W-DIV_W){1'b0}}, div_q};
      end else begin : g_div_full
         assign div_ext = div_q;
      end
   endgenerate

   assign rdata   = (sel == SEL_FRAME) ? frame_q : div_ext;
   assign frame   = frame_q;
   assign div     = div_q;
   assign pending = pend_q;
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] launch_div,
   input  logic             run,
   output logic             mdc,
   output logic             rise_ev,
   output logic             fall_ev
);
   logic [DIV_W-1:0] div_lat;
   logic [DIV_W-1:0] cnt;
   logic             mdc_q;
   logic             half_end;

   assign half_end = run && (cnt == div_lat - 1'b1);
   assign rise_ev  = half_end && !mdc_q;
   assign fall_ev  = half_end && mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_lat <= '0;
         cnt     <= '0;
         mdc_q   <= 1'b0;
      end else if (start) begin
         div_lat <= launch_div;
         cnt     <= '0;
         mdc_q   <= 1'b0;
      end else if (run) begin
         if (half_end) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign mdc = mdc_q;
endmodule

// File: rtl/mdio_bit_seq.sv
module mdio_bit_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               rise_ev,
   input  logic               fall_ev,
   input  logic [FRAME_W-1:0] frame,
   input  logic               mdio_i,
   output logic               busy,
   output logic               done,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               cap_en,
   output logic [POS_W-1:0]   cap_pos,
   output logic               cap_bit
);
   localparam int TOTAL_BITS = PRE_LEN + FRAME_W;
   localparam int IDX_W      = $clog2(TOTAL_BITS);
   localparam int REL_FIRST  = PRE_LEN + FRAME_W - DATA_W - 1;
   localparam int CAP_FIRST  = REL_FIRST + 1;

   logic [IDX_W-1:0]      idx;
   logic [IDX_W-1:0]      bit_sel;
   logic [TOTAL_BITS-1:0] tx_vec;
   logic                  busy_q;
   logic                  done_q;
   logic                  is_read;
   logic                  released;

   generate
      if (PRE_LEN > 0) begin : g_pre
         assign tx_vec = {{PRE_LEN{1'b1}}, frame};
      end else begin : g_nopre
         assign tx_vec = frame;
      end
   endgenerate

   assign bit_sel  = IDX_W'(TOTAL_BITS-1) - idx;
   assign is_read  = (frame[FRAME_W-3 -: 2] == OP_READ);
   assign released = is_read && (idx >= IDX_W'(REL_FIRST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx    <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            idx    <= '0;
         end else if (busy_q && fall_ev) begin
            if (idx == IDX_W'(TOTAL_BITS-1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign mdio_o  = busy_q ? tx_vec[bit_sel] : 1'b1;
   assign mdio_oe = busy_q && !released;
   assign cap_en  = busy_q && rise_ev && is_read && (idx >= IDX_W'(CAP_FIRST));
   assign cap_pos = POS_W'(bit_sel);
   assign cap_bit = mdio_i;
   assign busy    = busy_q;
   assign done    = done_q;
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mdio_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_sel,
   input  logic [FRAME_W-1:0] reg_wdata,
   output logic [FRAME_W-1:0] reg_rdata,
   input  logic               mdio_i,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               frame_done
);
   generate
      if (DIV_W < 1 || DIV_W > FRAME_W) begin : g_bad_div
         $error("DIV_W must lie in 1..FRAME_W");
      end
      if (PRE_LEN < 0 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must lie in 0..64");
      end
   endgenerate

   logic [FRAME_W-1:0] frame_val;
   logic [DIV_W-1:0]   div_val;
   logic [DIV_W-1:0]   launch_div;
   logic [POS_W-1:0]   cap_pos;
   logic               pend;
   logic               start;
   logic               busy;
   logic               rise_ev;
   logic               fall_ev;
   logic               cap_en;
   logic               cap_bit;

   mdio_regs #(.DIV_W(DIV_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .sel        (reg_sel),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .busy       (busy),
      .cap_en     (cap_en),
      .cap_pos    (cap_pos),
      .cap_bit    (cap_bit),
      .frame      (frame_val),
      .div        (div_val),
      .pending    (pend),
      .start      (start),
      .launch_div (launch_div)
   );

   mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .launch_div (launch_div),
      .run        (busy),
      .mdc        (mdc),
      .rise_ev    (rise_ev),
      .fall_ev    (fall_ev)
   );

   mdio_bit_seq #(.PRE_LEN(PRE_LEN)) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .rise_ev (rise_ev),
      .fall_ev (fall_ev),
      .frame   (frame_val),
      .mdio_i  (mdio_i),
      .busy    (busy),
      .done    (frame_done),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .cap_en  (cap_en),
      .cap_pos (cap_pos),
      .cap_bit (cap_bit)
   );
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_sel,
   input logic [DIV_W-1:0] div_wdata,
   input logic             mdc,
   input logic             mdio_o,
   input logic             mdio_oe,
   input logic             frame_done,
   input logic             busy,
   input logic             pend,
   input logic [DIV_W-1:0] div_val,
   input logic [15:0]      frame_hi
);
   // R1: accepted frame write with nonzero divider begins a frame
   a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && !busy && div_val != '0) |=> busy);

   // R3: frame write with zero divider is held
   a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && !busy && div_val == '0) |=> (!busy && pend));

   // R4: nonzero divider write launches the pending frame
   a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel && pend && !busy && div_wdata != '0) |=> (busy && !pend));

   // R2: clock parked low when idle
   a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R5: driven data moves only on a falling clock
   a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

   // R6: single-cycle completion pulse at the last falling edge
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> ($fell(mdc) && !busy));

   // R8: frame fields cannot change while a frame runs
   a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(frame_hi));
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.DIV_W(DIV_W)) chk_i (
   .div_wdata (reg_wdata[DIV_W-1:0]),
   .frame_hi  (frame_val[31:16]),
   .*
);

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_W = 8;

   typedef struct packed {
      logic [31:0] frame;
      logic [7:0]  div;
      logic [15:0] phy;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdio_i = 1'b1;
   logic        mdc, mdio_o, mdio_oe, frame_done;

   exp_t        exp_q[$];
   int          n_checks = 0;
   int          n_fail = 0;
   int          frames_done = 0;
   int          toggles_seen = 0;
   bit          finished = 0;

   mdio_frame_master #(.DIV_W(DIV_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .frame_done(frame_done)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                      input logic [4:0] ra, input logic [1:0] ta,
                                      input logic [15:0] d);
      return {2'b01, op, pa, ra, ta, d};
   endfunction

   task automatic reg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic sel, output logic [31:0] d);
      @(negedge clk);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic send(input logic [31:0] f, input logic [7:0] dv, input logic [15:0] phy);
      exp_q.push_back('{frame: f, div: dv, phy: phy});
      reg_write(1'b0, f);
   endtask

   task automatic wait_done();
      int target;
      target = frames_done + 1;
      while (frames_done < target) @(negedge clk);
   endtask

   // scoreboard monitor and PHY responder
   initial begin
      logic        prev_mdc, prev_done, rate_ok;
      logic [63:0] bits_v, oe_v, exp_bits, oe_exp;
      int          rise_cnt, cyc_since, nb;
      exp_t        e;
      prev_mdc = 0; prev_done = 0; rate_ok = 1;
      bits_v = '0; oe_v = '0; rise_cnt = 0; cyc_since = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            cyc_since++;
            if (prev_done)
               check(!frame_done, "R6", "done width", 64'(frame_done), 64'd0);
            if (mdc != prev_mdc) begin
               toggles_seen++;
               if (rise_cnt > 0 && exp_q.size() > 0 && cyc_since != int'(exp_q[0].div))
                  rate_ok = 0;
               cyc_since = 0;
            end
            if (!prev_mdc && mdc) begin
               if (rise_cnt < 64) begin
                  bits_v[63-rise_cnt] = mdio_o;
                  oe_v[63-rise_cnt]   = mdio_oe;
               end
               rise_cnt++;
               nb = rise_cnt;
               if (exp_q.size() > 0 && nb >= 48 && nb <= 63)
                  mdio_i = exp_q[0].phy[63-nb];
               else
                  mdio_i = 1'b1;
            end
            if (frame_done) begin
               check(prev_mdc && !mdc, "R6", "done on final fall", {62'd0, prev_mdc, mdc}, 64'd2);
               if (exp_q.size() == 0) begin
                  check(0, "R8", "unexpected frame", bits_v, 64'd0);
               end else begin
                  e = exp_q.pop_front();
                  exp_bits = {32'hFFFF_FFFF, e.frame};
                  oe_exp = (e.frame[29:28] == 2'b10) ? ~64'h1_FFFF : ~64'd0;
                  check(rise_cnt == 64, "R1", "bit count", 64'(rise_cnt), 64'd64);
                  check(oe_v == oe_exp, "R7", "drive enable pattern", oe_v, oe_exp);
                  check((bits_v & oe_exp) == (exp_bits & oe_exp), "R1", "serial bits",
                        bits_v & oe_exp, exp_bits & oe_exp);
                  check(rate_ok, "R2", "MDC half period", 64'(rate_ok), 64'd1);
               end
               rise_cnt = 0; rate_ok = 1; mdio_i = 1'b1;
               frames_done++;
            end
            prev_mdc = mdc;
            prev_done = frame_done;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "R1", "watchdog expired", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      logic [31:0] rd, f1, f2, fp1, fp2;
      int t0, d0;
      repeat (4) @(negedge clk);
      // R10: reset state
      check(!mdc, "R10", "mdc at reset", 64'(mdc), 64'd0);
      check(!mdio_oe, "R10", "oe at reset", 64'(mdio_oe), 64'd0);
      check(!frame_done, "R10", "done at reset", 64'(frame_done), 64'd0);
      rst_n = 1'b1;
      reg_read(1'b1, rd);
      check(rd == 32'd0, "R9", "divider reset value", rd, 32'd0);

      reg_write(1'b1, 32'd2);
      reg_read(1'b1, rd);
      check(rd == 32'd2, "R9", "divider readback", rd, 32'd2);

      // R1: write frame
      f1 = mk(2'b01, 5'h03, 5'h04, 2'b10, 16'hA5C3);
      send(f1, 8'd2, 16'h0);
      wait_done();
      reg_read(1'b0, rd);
      check(rd == f1, "R1", "write frame kept", rd, f1);

      // R7: read frame with PHY data
      f2 = mk(2'b10, 5'h11, 5'h02, 2'b11, 16'h0000);
      send(f2, 8'd2, 16'h9C3E);
      wait_done();
      reg_read(1'b0, rd);
      check(rd == {f2[31:16], 16'h9C3E}, "R7", "read data capture", rd, {f2[31:16], 16'h9C3E});

      // R2: fastest rate
      reg_write(1'b1, 32'd1);
      send(mk(2'b01, 5'h1F, 5'h00, 2'b10, 16'h0001), 8'd1, 16'h0);
      wait_done();

      // R8: writes during a frame are ignored
      reg_write(1'b1, 32'd3);
      f1 = mk(2'b01, 5'h0A, 5'h15, 2'b10, 16'h3C5A);
      send(f1, 8'd3, 16'h0);
      repeat (100) @(negedge clk);
      reg_write(1'b0, 32'h5555_AAAA);
      wait_done();
      reg_read(1'b0, rd);
      check(rd == f1, "R8", "frame word after busy write", rd, f1);
      t0 = frames_done;
      repeat (300) @(negedge clk);
      check(frames_done == t0 && !mdc, "R8", "no extra frame", 64'(frames_done - t0), 64'd0);

      // R9: divider change mid-frame keeps the running rate
      send(mk(2'b10, 5'h05, 5'h1E, 2'b11, 16'hFFFF), 8'd3, 16'h1234);
      repeat (50) @(negedge clk);
      reg_write(1'b1, 32'd4);
      wait_done();
      reg_read(1'b1, rd);
      check(rd == 32'd4, "R9", "divider after mid-frame write", rd, 32'd4);
      send(mk(2'b01, 5'h07, 5'h09, 2'b10, 16'h8001), 8'd4, 16'h0);
      wait_done();

      // R3: divider zero holds the frame
      reg_write(1'b1, 32'd0);
      fp1 = mk(2'b01, 5'h01, 5'h01, 2'b10, 16'hBEEF);
      reg_write(1'b0, fp1);
      d0 = toggles_seen;
      repeat (200) @(negedge clk);
      check(toggles_seen == d0 && !mdio_oe, "R3", "no activity while divider zero",
            64'(toggles_seen - d0), 64'd0);
      reg_read(1'b0, rd);
      check(rd == fp1, "R3", "held frame readback", rd, fp1);

      // R4: overwrite pending, zero divider keeps it pending, nonzero launches
      fp2 = mk(2'b10, 5'h12, 5'h03, 2'b11, 16'h0000);
      reg_write(1'b0, fp2);
      reg_write(1'b1, 32'd0);
      repeat (100) @(negedge clk);
      check(toggles_seen == d0 && frames_done == t0 + 2, "R4", "zero divider keeps pending",
            64'(toggles_seen - d0), 64'd0);
      exp_q.push_back('{frame: fp2, div: 8'd2, phy: 16'h6A91});
      reg_write(1'b1, 32'd2);
      wait_done();
      reg_read(1'b0, rd);
      check(rd == {fp2[31:16], 16'h6A91}, "R4", "launched pending read frame", rd,
            {fp2[31:16], 16'h6A91});

      // R1: back-to-back frame after pending launch
      send(mk(2'b01, 5'h00, 5'h1F, 2'b10, 16'h7E00), 8'd2, 16'h0);
      wait_done();
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R1", "scoreboard drained", 64'(exp_q.size()), 64'd0);
      finish_run();
   end
endmodule